// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the 32-bit status and control word that sits next to a floating-point datapath. It has three update paths and one read path. A compare-result port loads the four condition flags in the top nibble. A software write port loads the control fields. A datapath port sets sticky exception flags in the low five bits. The read port returns the whole word, with the vector length and vector stride fields put back in place.

The datapath gets the current rounding mode as a one-hot select, plus the vector length and the vector stride. The block does not compare operands or detect NaNs. It takes an already-decoded relation code and two NaN-kind indications from the datapath. It supports a quiet compare and an exception-raising compare, and these differ only in which NaN operands raise the invalid flag.

Top module: `fp_status_ctrl_reg`

## Requirements
- R1: A compare with relation code 0 (equal) loads 4'b0110 into read bits 31:28 on the next clock edge.
- R2: A compare with relation code 1 (less) loads 4'b1000 into read bits 31:28.
- R3: A compare with relation code 2 (greater) loads 4'b0010 into read bits 31:28.
- R4: A compare with relation code 3 (unordered) loads 4'b0011 into read bits 31:28.
- R5: A compare, with no software write in the same cycle, leaves read bits 27:5 unchanged.
- R6: A software write does the following:
  - It stores the written value ANDed with 32'hffc8ffff.
  - It loads the vector length from bits 18:16 and the vector stride from bits 21:20 into separate registers, which drive vec_len and vec_stride.
  - A read returns the stored word ORed with the length at bits 18:16 and the stride at bits 21:20.
- R7: round_sel is one-hot and decodes stored bits 23:22:
  - 0 gives bit 0 (nearest even).
  - 1 gives bit 1 (toward +infinity).
  - 2 gives bit 2 (toward -infinity).
  - 3 gives bit 3 (toward zero).
- R8: exc_pulse bit i sets read bit i. The bit order is invalid = 0, divide-by-zero = 1, overflow = 2, underflow = 3, inexact = 4.
- R9: Exception flags are sticky. They clear only through reset or a software write. A pulse in the same cycle as a write is ORed into the written bits 4:0.
- R10: The compare sets the invalid flag (bit 0) as follows:
  - A quiet compare (cmp_raise = 0) sets it only when cmp_snan is high.
  - An exception-raising compare (cmp_raise = 1) sets it when either cmp_snan or cmp_qnan is high.
- R11: A synchronous active-high reset clears the stored word, the length and the stride. After reset, round_sel is 4'b0001.
- R12: When a compare and a software write occur in the same cycle, the compare sets bits 31:28 and the write sets every other field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare result present this cycle |
| cmp_rel | input | 2 | Relation: 0 equal, 1 less, 2 greater, 3 unordered |
| cmp_raise | input | 1 | 1 = exception-raising compare, 0 = quiet compare |
| cmp_qnan | input | 1 | An operand is a quiet NaN |
| cmp_snan | input | 1 | An operand is a signaling NaN |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write value |
| exc_pulse | input | 5 | Single-cycle exception flags from the datapath |
| rd_data | output | 32 | Reassembled status/control word |
| round_sel | output | 4 | One-hot rounding mode |
| vec_len | output | 3 | Vector length |
| vec_stride | output | 2 | Vector stride |

## Verification
A software write can land in the same cycle as a compare, and it can also land in the same cycle as a datapath exception pulse. In both cases the write and the other update must merge correctly. The bench forces these collisions in directed steps: a write of all ones alongside an unordered compare, and a write of zero alongside a pulse. It then also lets them occur at random. A behavioural reference model predicts the next word from the inputs of each cycle. The bench compares the model against every output after each edge, field by field, so a wrong priority or a lost pulse shows up in the field it corrupts.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;

    localparam int WORD_W    = 32;
    localparam int NZCV_W    = 4;
    localparam int EXC_W     = 5;
    localparam int LEN_W     = 3;
    localparam int STRIDE_W  = 2;
    localparam int RMODE_W   = 2;
    localparam int LEN_LSB   = 16;
    localparam int STR_LSB   = 20;
    localparam int RM_LSB    = 22;
    localparam int NZCV_LSB  = WORD_W - NZCV_W;
    localparam int CTRL_LSB  = EXC_W;
    localparam int CTRL_W    = NZCV_LSB - CTRL_LSB;
    localparam int NUM_RMODE = 1 << RMODE_W;

    localparam logic [WORD_W-1:0] STORE_MASK = 32'hffc8_ffff;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic [RMODE_W-1:0] {
        RM_NEAREST = 2'd0,
        RM_POS_INF = 2'd1,
        RM_NEG_INF = 2'd2,
        RM_ZERO    = 2'd3
    } rmode_e;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic div_zero;
        logic invalid;
    } exc_t;

    typedef struct packed {
        logic              valid;
        rel_e              rel;
        logic              raise;
        logic              qnan;
        logic              snan;
    } cmp_req_t;

    function automatic logic [NZCV_W-1:0] rel_to_nzcv(rel_e r);
        logic [NZCV_W-1:0] f;
        unique case (r)
            REL_EQ:  f = 4'b0110;
            REL_LT:  f = 4'b1000;
            REL_GT:  f = 4'b0010;
            default: f = 4'b0011;
        endcase
        return f;
    endfunction

    function automatic logic cmp_invalid(cmp_req_t c);
        logic hit;
        hit = c.snan | (c.raise & c.qnan);
        return c.valid & hit;
    endfunction

    function automatic logic [NUM_RMODE-1:0] rmode_onehot(rmode_e m);
        logic [NUM_RMODE-1:0] oh;
        oh = '0;
        oh[m] = 1'b1;
        return oh;
    endfunction

endpackage

// File: rtl/fpscr_cond_unit.sv
module fpscr_cond_unit
    import fpscr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmp_req_t          cmp,
    input  logic              wr_en,
    input  logic [NZCV_W-1:0] wr_nzcv,
    output logic [NZCV_W-1:0] nzcv_q
);

    logic [NZCV_W-1:0] nzcv_d;

    // A compare outranks a software write in the same cycle.
    always_comb begin
        nzcv_d = nzcv_q;
        if (wr_en)
            nzcv_d = wr_nzcv;
        if (cmp.valid)
            nzcv_d = rel_to_nzcv(cmp.rel);
    end

    always_ff @(posedge clk) begin
        if (rst)
            nzcv_q <= '0;
        else
            nzcv_q <= nzcv_d;
    end

endmodule

// File: rtl/fpscr_ctrl_unit.sv
module fpscr_ctrl_unit
    import fpscr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [CTRL_W-1:0]    ctrl_q,
    output logic [LEN_W-1:0]     len_q,
    output logic [STRIDE_W-1:0]  stride_q,
    output logic [NUM_RMODE-1:0] round_sel
);

    localparam logic [CTRL_W-1:0] CTRL_MASK = STORE_MASK[NZCV_LSB-1:CTRL_LSB];
    localparam int RM_OFF = RM_LSB - CTRL_LSB;

    logic [CTRL_W-1:0] ctrl_masked;
    rmode_e            rmode;

    assign ctrl_masked = wr_data[NZCV_LSB-1:CTRL_LSB] & CTRL_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            len_q    <= '0;
            stride_q <= '0;
        end else if (wr_en) begin
            ctrl_q   <= ctrl_masked;
            len_q    <= wr_data[LEN_LSB +: LEN_W];
            stride_q <= wr_data[STR_LSB +: STRIDE_W];
        end
    end

    assign rmode     = rmode_e'(ctrl_q[RM_OFF +: RMODE_W]);
    assign round_sel = rmode_onehot(rmode);

endmodule

// File: rtl/fpscr_sticky_unit.sv
module fpscr_sticky_unit
    import fpscr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [EXC_W-1:0] wr_exc,
    input  exc_t             pulse,
    input  logic             cmp_inv,
    output exc_t             exc_q
);

    logic [EXC_W-1:0] set_vec;
    logic [EXC_W-1:0] q_vec;

    assign set_vec = pulse | {{(EXC_W-1){1'b0}}, cmp_inv};

    for (genvar i = 0; i < EXC_W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (wr_en)
                bit_q <= wr_exc[i] | set_vec[i];
            else
                bit_q <= bit_q | set_vec[i];
        end
        assign q_vec[i] = bit_q;
    end

    assign exc_q = exc_t'(q_vec);

endmodule

// File: rtl/fp_status_ctrl_reg.sv
module fp_status_ctrl_reg
    import fpscr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmp_valid,
    input  logic [1:0]  cmp_rel,
    input  logic        cmp_raise,
    input  logic        cmp_qnan,
    input  logic        cmp_snan,
    input  logic        sw_wr_en,
    input  logic [31:0] sw_wr_data,
    input  logic [4:0]  exc_pulse,
    output logic [31:0] rd_data,
    output logic [3:0]  round_sel,
    output logic [2:0]  vec_len,
    output logic [1:0]  vec_stride
);

    cmp_req_t              cmp;
    logic [NZCV_W-1:0]     nzcv_q;
    logic [CTRL_W-1:0]     ctrl_q;
    logic [LEN_W-1:0]      len_q;
    logic [STRIDE_W-1:0]   stride_q;
    exc_t                  exc_q;
    logic [WORD_W-1:0]     stored;
    logic [WORD_W-1:0]     fields;

    assign cmp = '{valid: cmp_valid, rel: rel_e'(cmp_rel), raise: cmp_raise,
                   qnan: cmp_qnan, snan: cmp_snan};

    fpscr_cond_unit u_cond (
        .clk     (clk),
        .rst     (rst),
        .cmp     (cmp),
        .wr_en   (sw_wr_en),
        .wr_nzcv (sw_wr_data[WORD_W-1:NZCV_LSB]),
        .nzcv_q  (nzcv_q)
    );

    fpscr_ctrl_unit u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (sw_wr_en),
        .wr_data   (sw_wr_data),
        .ctrl_q    (ctrl_q),
        .len_q     (len_q),
        .stride_q  (stride_q),
        .round_sel (round_sel)
    );

    fpscr_sticky_unit u_sticky (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sw_wr_en),
        .wr_exc  (sw_wr_data[EXC_W-1:0]),
        .pulse   (exc_t'(exc_pulse)),
        .cmp_inv (cmp_invalid(cmp)),
        .exc_q   (exc_q)
    );

    always_comb begin
        stored = {nzcv_q, ctrl_q, exc_q};
        fields = '0;
        fields[LEN_LSB +: LEN_W]    = len_q;
        fields[STR_LSB +: STRIDE_W] = stride_q;
        rd_data = stored | fields;
    end

    assign vec_len    = len_q;
    assign vec_stride = stride_q;

endmodule

// File: rtl/fp_status_ctrl_reg_chk.sv
module fp_status_ctrl_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmp_valid,
    input logic [1:0]  cmp_rel,
    input logic        cmp_raise,
    input logic        cmp_qnan,
    input logic        cmp_snan,
    input logic        sw_wr_en,
    input logic [31:0] sw_wr_data,
    input logic [4:0]  exc_pulse,
    input logic [31:0] rd_data,
    input logic [3:0]  round_sel,
    input logic [2:0]  vec_len,
    input logic [1:0]  vec_stride
);

    AST_CMP_EQ: assert property (@(posedge clk) disable iff (rst)
        cmp_valid && cmp_rel == 2'd0 |=> rd_data[31:28] == 4'b0110); // R1
    AST_CMP_LT: assert property (@(posedge clk) disable iff (rst)
        cmp_valid && cmp_rel == 2'd1 |=> rd_data[31:28] == 4'b1000); // R2
    AST_CMP_GT: assert property (@(posedge clk) disable iff (rst)
        cmp_valid && cmp_rel == 2'd2 |=> rd_data[31:28] == 4'b0010); // R3
    AST_CMP_UN: assert property (@(posedge clk) disable iff (rst)
        cmp_valid && cmp_rel == 2'd3 |=> rd_data[31:28] == 4'b0011); // R4
    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (rst)
        cmp_valid && !sw_wr_en |=> $stable(rd_data[27:5])); // R5
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
        sw_wr_en |=> rd_data[27:5] == $past(sw_wr_data[27:5])
                     && vec_len == $past(sw_wr_data[18:16])
                     && vec_stride == $past(sw_wr_data[21:20])); // R6
    AST_ROUND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(round_sel) == 1); // R7
    AST_PULSE_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd_data[4:0] & $past(exc_pulse)) == $past(exc_pulse)); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sw_wr_en |=> (rd_data[4:0] & $past(rd_data[4:0])) == $past(rd_data[4:0])); // R9
    AST_SIG_INVALID: assert property (@(posedge clk) disable iff (rst)
        cmp_valid && cmp_raise && cmp_qnan |=> rd_data[0]); // R10

endmodule

bind fp_status_ctrl_reg fp_status_ctrl_reg_chk u_chk (.*);

// File: tb/fp_status_ctrl_reg_tb_top.sv
module fp_status_ctrl_reg_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_valid;
    logic [1:0]  cmp_rel;
    logic        cmp_raise;
    logic        cmp_qnan;
    logic        cmp_snan;
    logic        sw_wr_en;
    logic [31:0] sw_wr_data;
    logic [4:0]  exc_pulse;
    logic [31:0] rd_data;
    logic [3:0]  round_sel;
    logic [2:0]  vec_len;
    logic [1:0]  vec_stride;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_word;
    logic [2:0]  m_len;
    logic [1:0]  m_stride;
    string       nz_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_status_ctrl_reg dut_i (.*);

    function automatic logic [3:0] exp_flags(int rel);
        case (rel)
            0: return 4'b0110;
            1: return 4'b1000;
            2: return 4'b0010;
            default: return 4'b0011;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] exp_rd;
        exp_rd = m_word | {10'd0, m_stride, 1'b0, m_len, 16'd0};
        check({nz_tag, " flags"}, {28'd0, rd_data[31:28]}, {28'd0, exp_rd[31:28]});
        check("R6 R12 control bits", {9'd0, rd_data[27:5]}, {9'd0, exp_rd[27:5]});
        check("R9 R8 R10 exception bits", {27'd0, rd_data[4:0]}, {27'd0, exp_rd[4:0]});
        check("R6 length", {29'd0, vec_len}, {29'd0, m_len});
        check("R6 stride", {30'd0, vec_stride}, {30'd0, m_stride});
        check("R7 round select", {28'd0, round_sel}, 32'd1 << m_word[23:22]);
    endtask

    // Applies one cycle of stimulus, advances the model, checks after the edge.
    task automatic step(bit r, bit cv, int rel, bit raise, bit qn, bit sn,
                        bit we, logic [31:0] wd, logic [4:0] ep);
        logic [31:0] nw;
        logic inv;
        rst = r; cmp_valid = cv; cmp_rel = rel[1:0]; cmp_raise = raise;
        cmp_qnan = qn; cmp_snan = sn; sw_wr_en = we; sw_wr_data = wd;
        exc_pulse = ep;
        nw = m_word;
        if (r) begin
            m_word = '0; m_len = '0; m_stride = '0; nz_tag = "R11";
        end else begin
            if (we) begin
                nw = wd & 32'hffc8ffff;
                m_len = wd[18:16];
                m_stride = wd[21:20];
                nz_tag = "R12";
            end
            if (cv) begin
                nw[31:28] = exp_flags(rel);
                nz_tag = (rel == 0) ? "R1" : (rel == 1) ? "R2" : (rel == 2) ? "R3" : "R4";
                if (we) nz_tag = "R12";
            end
            inv = cv && (sn || (raise && qn));
            nw[4:0] = nw[4:0] | ep | {4'd0, inv};
            m_word = nw;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 32'd0, 5'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_word = '0; m_len = '0; m_stride = '0; nz_tag = "R11";
        @(negedge clk);
        // R11 reset state
        step(1, 0, 0, 0, 0, 0, 0, 32'd0, 5'd0);
        step(1, 1, 2, 1, 1, 1, 1, 32'hffff_ffff, 5'h1f);
        // R1..R4 each relation, R5 control bits hold
        step(0, 0, 0, 0, 0, 0, 1, 32'h0a5a_5a40, 5'd0);
        step(0, 1, 0, 0, 0, 0, 0, 32'd0, 5'd0);
        step(0, 1, 1, 0, 0, 0, 0, 32'd0, 5'd0);
        step(0, 1, 2, 0, 0, 0, 0, 32'd0, 5'd0);
        step(0, 1, 3, 0, 0, 0, 0, 32'd0, 5'd0);
        // R10 quiet compare: quiet NaN no invalid, signaling NaN sets it
        step(0, 1, 3, 0, 1, 0, 0, 32'd0, 5'd0);
        step(0, 0, 0, 0, 0, 0, 1, 32'd0, 5'd0);
        step(0, 1, 3, 0, 0, 1, 0, 32'd0, 5'd0);
        step(0, 0, 0, 0, 0, 0, 1, 32'd0, 5'd0);
        // R10 raising compare with quiet NaN sets invalid
        step(0, 1, 3, 1, 1, 0, 0, 32'd0, 5'd0);
        // R8 each exception bit position, R9 stickiness
        step(0, 0, 0, 0, 0, 0, 1, 32'd0, 5'd0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 0, 32'd0, 5'd1 << i);
        idle(); idle();
        // R9 write clears, pulse in same cycle merges
        step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0001, 5'h04);
        // R6 write of all ones: masked store, length/stride reassembled
        step(0, 0, 0, 0, 0, 0, 1, 32'hffff_ffff, 5'd0);
        // R12 write and unordered compare together
        step(0, 1, 1, 0, 0, 0, 1, 32'h0000_0000, 5'd0);
        step(0, 1, 3, 0, 0, 0, 1, 32'hffff_ffff, 5'd0);
        // R7 all rounding modes
        for (int m = 0; m < 4; m++) step(0, 0, 0, 0, 0, 0, 1, 32'(m) << 22, 5'd0);
        // mixed random traffic, rare reset
        for (int k = 0; k < 400; k++) begin
            int p;
            p = $urandom_range(0, 99);
            step(p == 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
                 $urandom, ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'd0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule